// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit linear address into a physical address. It reads a directory entry and then a table entry from memory through a simple request and acknowledge port, which carries one 32-bit word at a time. It checks the access rights of the operation against both entries. It sets the accessed and dirty flags in memory by writing the entries back. If a walk cannot complete, it reports a fault with an error code and the linear address that failed.

A requester presents an address with write, user-mode and write-protect qualifiers and a directory base, for one cycle, while the walker is idle. When the walk ends, the walker pulses either `done` with `paddr`, or `fault` with `fault_addr` and `fault_code`. Only one memory operation is outstanding at a time. Each request on the memory port stays asserted, with its address and data held, until the memory acknowledges it.

Top module: `page_walker`

## Requirements
- R1: The directory entry is read from `dir_base + 4*laddr[31:22]`.
- R2: The table entry is read from `{pde[31:12], 12'h000} + 4*laddr[21:12]`.
- R3: On success `paddr` = `{pte[31:12], laddr[11:0]}`.
- R4: If bit 0 (present) of the directory entry or of the table entry is 0, the walk stops at that entry with a fault whose code bit 0 is 0, and no further memory operation takes place.
- R5: If bit 5 (accessed) of the directory entry is 0, that entry is written back to the same address with bit 5 set, before the table entry is read.
- R6: If bit 5 of the table entry is 0, that entry is written back with bit 5 set, before the rights are checked.
- R7: The rights index is {wp_en, req_user, pde[2]&pte[2], pde[1]&pte[1], req_write}, with bit 4 at the left. The access is allowed only if that bit of the constant 32'hD0DDD0FF is 1.
- R8: A rights failure is a fault with code bit 0 equal to 1, and no dirty-bit write follows it.
- R9: An allowed write whose table entry has bit 6 (dirty) clear writes that entry back with bits 5 and 6 set, as the last memory operation. Reads and writes whose dirty bit is already set make no such write.
- R10: On a fault, `fault_addr` is the linear address of the request. `fault_code` bit 1 is the write flag and bit 2 is the user flag.
- R11: Once `mem_req` rises, it stays high with stable `mem_we`, `mem_addr` and `mem_wdata` until `mem_ack`. A new memory request is issued only after the previous one has been acknowledged.
- R12: `done` and `fault` are one-cycle pulses, never high together, and low after reset.
- R13: `req_valid` has no effect while a walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Starts a walk when the walker is idle |
| req_laddr | input | 32 | Linear address to translate |
| req_write | input | 1 | The operation is a write |
| req_user | input | 1 | The operation is made in user mode |
| wp_en | input | 1 | Write protection applies to supervisor writes |
| dir_base | input | 32 | Physical base address of the page directory |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | The request is a write |
| mem_addr | output | 32 | Word address of the entry |
| mem_wdata | output | 32 | Entry value to write back |
| mem_ack | input | 1 | Memory acknowledge; read data is valid with it |
| mem_rdata | input | 32 | Entry value read |
| done | output | 1 | Successful translation pulse |
| fault | output | 1 | Fault pulse |
| paddr | output | 32 | Physical address, valid with done |
| fault_addr | output | 32 | Linear address of the last fault |
| fault_code | output | 3 | Error code of the last fault |

## Verification
The hardest case to reach is the longest walk: both entries lack the accessed flag and the operation is a write to a clean page. This gives five memory operations whose order must be exact, under a memory whose acknowledge latency varies. The bench models memory itself, with an adjustable latency. It presets the entries before each walk and compares the logged sequence of operations, and the entry words left in memory, against values computed from the entries beforehand. All 32 rights indices are swept through preset entry flags, and a second request is injected in the middle of a walk to show that it is dropped.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int ENT_P     = 0;
  localparam int ENT_RW    = 1;
  localparam int ENT_US    = 2;
  localparam int ENT_A     = 5;
  localparam int ENT_D     = 6;
  localparam int ENT_SHIFT = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_DIR_WB,
    ST_TBL_RD,
    ST_TBL_WB_A,
    ST_CHECK,
    ST_TBL_WB_D
  } walk_state_t;

  typedef struct packed {
    logic wp;
    logic user;
    logic us;
    logic rw;
    logic wr;
  } rights_idx_t;
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
  parameter int OFS_W = 12,
  parameter int IDX_W = 10,
  localparam int AW = OFS_W + 2 * IDX_W
) (
  input  logic [AW-1:0]    dir_base,
  input  logic [AW-1:0]    laddr,
  input  logic [AW-OFS_W-1:0] pde_frame,
  input  logic [AW-OFS_W-1:0] pte_frame,
  output logic [AW-1:0]    dir_ent_addr,
  output logic [AW-1:0]    tbl_ent_addr,
  output logic [AW-1:0]    phys_addr
);
  import pw_pkg::*;

  logic [AW-1:0] dir_off;
  logic [AW-1:0] tbl_off;

  always_comb begin
    dir_off      = AW'(laddr[AW-1 -: IDX_W]) << ENT_SHIFT;
    tbl_off      = AW'(laddr[OFS_W +: IDX_W]) << ENT_SHIFT;
    dir_ent_addr = dir_base + dir_off;
    tbl_ent_addr = {pde_frame, {OFS_W{1'b0}}} + tbl_off;
    phys_addr    = {pte_frame, laddr[OFS_W-1:0]};
  end
endmodule

// File: rtl/pw_rights.sv
module pw_rights #(
  parameter logic [31:0] ALLOW_MASK = 32'hD0DDD0FF
) (
  input  logic wr,
  input  logic user,
  input  logic wp,
  input  logic pde_rw,
  input  logic pde_us,
  input  logic pte_rw,
  input  logic pte_us,
  output logic allowed
);
  import pw_pkg::*;

  rights_idx_t idx;

  always_comb begin
    idx.wp   = wp;
    idx.user = user;
    idx.us   = pde_us & pte_us;
    idx.rw   = pde_rw & pte_rw;
    idx.wr   = wr;
    allowed  = ALLOW_MASK[idx];
  end
endmodule

// File: rtl/pw_mem_port.sv
module pw_mem_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_we,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  assign rsp_valid = mem_req & mem_ack;
  assign rsp_data  = mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (start) begin
      mem_req   <= 1'b1;
      mem_we    <= start_we;
      mem_addr  <= start_addr;
      mem_wdata <= start_wdata;
    end else if (mem_ack) begin
      mem_req   <= 1'b0;
    end
  end
endmodule

// File: rtl/page_walker.sv
module page_walker #(
  parameter int          OFS_W      = 12,
  parameter int          IDX_W      = 10,
  parameter int          FC_W       = 3,
  parameter logic [31:0] ALLOW_MASK = 32'hD0DDD0FF,
  localparam int         ADDR_W     = OFS_W + 2 * IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_laddr,
  input  logic              req_write,
  input  logic              req_user,
  input  logic              wp_en,
  input  logic [ADDR_W-1:0] dir_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              done,
  output logic              fault,
  output logic [ADDR_W-1:0] paddr,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [FC_W-1:0]   fault_code
);
  import pw_pkg::*;

  localparam int FR_W = ADDR_W - OFS_W;
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(1) << ENT_A;
  localparam logic [ADDR_W-1:0] D_MASK = ADDR_W'(1) << ENT_D;

  walk_state_t state, nxt;

  logic [ADDR_W-1:0] lat_laddr;
  logic              lat_wr, lat_user, lat_wp;
  logic [FR_W-1:0]   pde_frame_q;
  logic              pde_rw_q, pde_us_q;
  logic [ADDR_W-1:0] pte_q;

  logic              start, start_we;
  logic [ADDR_W-1:0] start_addr, start_wdata;
  logic              rsp_valid;
  logic [ADDR_W-1:0] rsp_data;
  logic              fin_ok, fin_flt, flt_rights;

  logic [ADDR_W-1:0] walk_laddr;
  logic [FR_W-1:0]   pde_frame_cur;
  logic [ADDR_W-1:0] dir_ent_addr, tbl_ent_addr, phys_addr;
  logic              allowed;

  assign walk_laddr    = (state == ST_IDLE) ? req_laddr : lat_laddr;
  assign pde_frame_cur = (state == ST_DIR_RD) ? rsp_data[ADDR_W-1:OFS_W] : pde_frame_q;

  pw_addr_gen #(.OFS_W(OFS_W), .IDX_W(IDX_W)) u_addr (
    .dir_base    (dir_base),
    .laddr       (walk_laddr),
    .pde_frame   (pde_frame_cur),
    .pte_frame   (pte_q[ADDR_W-1:OFS_W]),
    .dir_ent_addr(dir_ent_addr),
    .tbl_ent_addr(tbl_ent_addr),
    .phys_addr   (phys_addr)
  );

  pw_rights #(.ALLOW_MASK(ALLOW_MASK)) u_rights (
    .wr     (lat_wr),
    .user   (lat_user),
    .wp     (lat_wp),
    .pde_rw (pde_rw_q),
    .pde_us (pde_us_q),
    .pte_rw (pte_q[ENT_RW]),
    .pte_us (pte_q[ENT_US]),
    .allowed(allowed)
  );

  pw_mem_port #(.AW(ADDR_W), .DW(ADDR_W)) u_port (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_we   (start_we),
    .start_addr (start_addr),
    .start_wdata(start_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data)
  );

  // Next-state and memory-issue logic
  always_comb begin
    nxt         = state;
    start       = 1'b0;
    start_we    = 1'b0;
    start_addr  = mem_addr;
    start_wdata = '0;
    fin_ok      = 1'b0;
    fin_flt     = 1'b0;
    flt_rights  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req_valid) begin
          start      = 1'b1;
          start_addr = dir_ent_addr;
          nxt        = ST_DIR_RD;
        end
      end
      ST_DIR_RD: begin
        if (rsp_valid) begin
          if (!rsp_data[ENT_P]) begin
            fin_flt = 1'b1;
            nxt     = ST_IDLE;
          end else if (!rsp_data[ENT_A]) begin
            start       = 1'b1;
            start_we    = 1'b1;
            start_wdata = rsp_data | A_MASK;
            nxt         = ST_DIR_WB;
          end else begin
            start      = 1'b1;
            start_addr = tbl_ent_addr;
            nxt        = ST_TBL_RD;
          end
        end
      end
      ST_DIR_WB: begin
        if (rsp_valid) begin
          start      = 1'b1;
          start_addr = tbl_ent_addr;
          nxt        = ST_TBL_RD;
        end
      end
      ST_TBL_RD: begin
        if (rsp_valid) begin
          if (!rsp_data[ENT_P]) begin
            fin_flt = 1'b1;
            nxt     = ST_IDLE;
          end else if (!rsp_data[ENT_A]) begin
            start       = 1'b1;
            start_we    = 1'b1;
            start_wdata = rsp_data | A_MASK;
            nxt         = ST_TBL_WB_A;
          end else begin
            nxt = ST_CHECK;
          end
        end
      end
      ST_TBL_WB_A: begin
        if (rsp_valid) nxt = ST_CHECK;
      end
      ST_CHECK: begin
        if (!allowed) begin
          fin_flt    = 1'b1;
          flt_rights = 1'b1;
          nxt        = ST_IDLE;
        end else if (lat_wr && !pte_q[ENT_D]) begin
          start       = 1'b1;
          start_we    = 1'b1;
          start_wdata = pte_q | D_MASK;
          nxt         = ST_TBL_WB_D;
        end else begin
          fin_ok = 1'b1;
          nxt    = ST_IDLE;
        end
      end
      ST_TBL_WB_D: begin
        if (rsp_valid) begin
          fin_ok = 1'b1;
          nxt    = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // State, captured entries and registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      lat_laddr   <= '0;
      lat_wr      <= 1'b0;
      lat_user    <= 1'b0;
      lat_wp      <= 1'b0;
      pde_frame_q <= '0;
      pde_rw_q    <= 1'b0;
      pde_us_q    <= 1'b0;
      pte_q       <= '0;
      done        <= 1'b0;
      fault       <= 1'b0;
      paddr       <= '0;
      fault_addr  <= '0;
      fault_code  <= '0;
    end else begin
      state <= nxt;
      done  <= fin_ok;
      fault <= fin_flt;
      if (state == ST_IDLE && req_valid) begin
        lat_laddr <= req_laddr;
        lat_wr    <= req_write;
        lat_user  <= req_user;
        lat_wp    <= wp_en;
      end
      if (state == ST_DIR_RD && rsp_valid) begin
        pde_frame_q <= rsp_data[ADDR_W-1:OFS_W];
        pde_rw_q    <= rsp_data[ENT_RW];
        pde_us_q    <= rsp_data[ENT_US];
      end
      if (state == ST_TBL_RD && rsp_valid) begin
        pte_q <= rsp_data | A_MASK;
      end
      if (fin_ok) begin
        paddr <= phys_addr;
      end
      if (fin_flt) begin
        fault_addr <= lat_laddr;
        fault_code <= FC_W'({lat_user, lat_wr, flt_rights});
      end
    end
  end
endmodule

// File: rtl/pw_checker.sv
module pw_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          done,
  input logic          fault,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata
);
  logic [AW-1:0] last_rd_addr;

  always_ff @(posedge clk) begin
    if (rst) last_rd_addr <= '0;
    else if (mem_req && mem_ack && !mem_we) last_rd_addr <= mem_addr;
  end

  assert_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_fault_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    fault |=> !fault);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_wb_same_addr_R5: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_addr == last_rd_addr);

  assert_wb_accessed_R6: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_wdata[5]);
endmodule

bind page_walker pw_checker #(.AW(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .done     (done),
  .fault    (fault),
  .mem_req  (mem_req),
  .mem_ack  (mem_ack),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata)
);

// File: tb/page_walker_test.sv
`timescale 1ns/1ps
module page_walker_test;
  localparam logic [31:0] MASK = 32'hD0DDD0FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_laddr = '0;
  logic        req_write = 1'b0, req_user = 1'b0, wp_en = 1'b0;
  logic [31:0] dir_base = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done, fault;
  logic [31:0] paddr, fault_addr;
  logic [2:0]  fault_code;

  always #2 clk = ~clk;

  page_walker uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_laddr(req_laddr),
    .req_write(req_write), .req_user(req_user), .wp_en(wp_en), .dir_base(dir_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .fault(fault),
    .paddr(paddr), .fault_addr(fault_addr), .fault_code(fault_code)
  );

  // Memory model with adjustable latency and an operation log
  logic [31:0] mem [4096];
  logic [32:0] log_q[$];
  int lat = 0;
  int cnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      cnt     <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (cnt >= lat) begin
        mem_ack <= 1'b1;
        cnt     <= 0;
        if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
        else        mem_rdata <= mem[mem_addr[13:2]];
        log_q.push_back({mem_we, mem_addr});
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  typedef struct packed {
    logic             flt;
    logic [31:0]      pa;
    logic [2:0]       code;
    logic [31:0]      fa;
    logic [2:0]       nops;
    logic [4:0][32:0] ops;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // Reference walk computed from the requirements and the current memory
  function automatic exp_t predict(input logic [31:0] la, input logic wr,
                                   input logic us, input logic wp, input logic [31:0] base);
    exp_t e;
    logic [31:0] a_d, a_t, pde, pte;
    logic [4:0]  idx;
    e = '0;
    e.fa = la;
    a_d = base + {20'd0, la[31:22], 2'b00};
    pde = mem[a_d[13:2]];
    e.ops[0] = {1'b0, a_d}; e.nops = 3'd1;
    if (!pde[0]) begin e.flt = 1; e.code = {us, wr, 1'b0}; return e; end
    if (!pde[5]) begin e.ops[e.nops] = {1'b1, a_d}; e.nops++; pde[5] = 1'b1; end
    a_t = {pde[31:12], 12'h000} + {20'd0, la[21:12], 2'b00};
    pte = mem[a_t[13:2]];
    e.ops[e.nops] = {1'b0, a_t}; e.nops++;
    if (!pte[0]) begin e.flt = 1; e.code = {us, wr, 1'b0}; return e; end
    if (!pte[5]) begin e.ops[e.nops] = {1'b1, a_t}; e.nops++; end
    idx = {wp, us, pde[2] & pte[2], pde[1] & pte[1], wr};
    if (!MASK[idx]) begin e.flt = 1; e.code = {us, wr, 1'b1}; return e; end
    if (wr && !pte[6]) begin e.ops[e.nops] = {1'b1, a_t}; e.nops++; end
    e.pa = {pte[31:12], la[11:0]};
    return e;
  endfunction

  // Driver: predicts, pushes, issues and waits for the monitor to consume
  task automatic walk(input logic [31:0] la, input logic wr, input logic us,
                      input logic wp, input logic [31:0] base, input string tag);
    exp_q.push_back(predict(la, wr, us, wp, base));
    tag_q.push_back(tag);
    log_q.delete();
    @(negedge clk);
    req_valid = 1; req_laddr = la; req_write = wr; req_user = us; wp_en = wp; dir_base = base;
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k < 400 && exp_q.size() != 0; k++) @(negedge clk);
    if (exp_q.size() != 0) begin
      check(0, tag, "walk timeout", 64'(exp_q.size()), 0);
      exp_q.delete(); tag_q.delete();
    end
  endtask

  // Monitor: pops the expectation when a result strobe is seen
  always @(negedge clk) begin
    if (!rst && (done || fault)) begin
      if (exp_q.size() == 0) begin
        check(0, "R13", "unexpected result strobe", {62'd0, done, fault}, 0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(!(done && fault), "R12", "done and fault together", {62'd0, done, fault}, 0);
        check(fault == e.flt, t, "outcome fault", 64'(fault), 64'(e.flt));
        if (!e.flt && done) check(paddr == e.pa, "R3", "paddr", 64'(paddr), 64'(e.pa));
        if (e.flt && fault) begin
          check(fault_addr == e.fa, "R10", "fault_addr", 64'(fault_addr), 64'(e.fa));
          check(fault_code == e.code, "R10", "fault_code", 64'(fault_code), 64'(e.code));
        end
        check(log_q.size() == int'(e.nops), t, "memory op count",
              64'(log_q.size()), 64'(e.nops));
        for (int k = 0; k < int'(e.nops) && k < log_q.size(); k++)
          check(log_q[k] == e.ops[k], t, "memory op", 64'(log_q[k]), 64'(e.ops[k]));
      end
    end
  end

  // Global watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  localparam logic [31:0] LA = 32'h0040_5123;  // dir idx 1, tbl idx 5
  localparam logic [31:0] PDE_A = 32'h0000_0004;
  localparam logic [31:0] PTE_A = 32'h0000_1014;

  initial begin
    for (int k = 0; k < 4096; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(!done && !fault, "R12", "reset strobes", {62'd0, done, fault}, 0);
    check(!mem_req, "R11", "reset mem_req", 64'(mem_req), 0);

    // R7: sweep of all rights indices, latency varies
    for (int i = 0; i < 32; i++) begin
      logic [31:0] la;
      lat = i % 3;
      mem[PDE_A[13:2]] = 32'h0000_1027;
      mem[PTE_A[13:2]] = 32'hABCD_E061 | (32'(i[2]) << 2) | (32'(i[1]) << 1);
      la = LA ^ 32'(i * 37);
      la[31:12] = LA[31:12];
      walk(la, i[0], i[3], i[4], 32'h0, "R7");
    end

    // R5: directory entry without accessed flag
    lat = 1;
    mem[PDE_A[13:2]] = 32'h0000_1007;
    mem[PTE_A[13:2]] = 32'h1234_5067;
    walk(LA, 0, 0, 0, 32'h0, "R5");
    check(mem[PDE_A[13:2]] == 32'h0000_1027, "R5", "pde after walk",
          64'(mem[PDE_A[13:2]]), 64'h1027);

    // R6 and R9: longest walk, both entries clean and unaccessed, write
    lat = 2;
    mem[PDE_A[13:2]] = 32'h0000_1007;
    mem[PTE_A[13:2]] = 32'h1234_5007;
    walk(LA, 1, 1, 1, 32'h0, "R9");
    check(mem[PTE_A[13:2]] == 32'h1234_5067, "R6", "pte after write walk",
          64'(mem[PTE_A[13:2]]), 64'h12345067);
    check(mem[PDE_A[13:2]] == 32'h0000_1027, "R5", "pde after write walk",
          64'(mem[PDE_A[13:2]]), 64'h1027);

    // R9: read does not dirty the page
    lat = 0;
    mem[PTE_A[13:2]] = 32'h1234_5027;
    walk(LA, 0, 1, 0, 32'h0, "R9");
    check(mem[PTE_A[13:2]] == 32'h1234_5027, "R9", "pte after read",
          64'(mem[PTE_A[13:2]]), 64'h12345027);

    // R8: denied write to a clean page leaves no dirty write
    mem[PTE_A[13:2]] = 32'h1234_5025;
    walk(LA, 1, 1, 0, 32'h0, "R8");
    check(mem[PTE_A[13:2]] == 32'h1234_5025, "R8", "pte after denied write",
          64'(mem[PTE_A[13:2]]), 64'h12345025);

    // R7: rights are the AND of both levels (directory read-only)
    mem[PDE_A[13:2]] = 32'h0000_1025;
    mem[PTE_A[13:2]] = 32'h1234_5067;
    walk(LA, 1, 1, 0, 32'h0, "R7");

    // R4: directory entry not present, then table entry not present
    mem[PDE_A[13:2]] = 32'h0000_1026;
    walk(LA, 1, 1, 0, 32'h0, "R4");
    mem[PDE_A[13:2]] = 32'h0000_1027;
    mem[PTE_A[13:2]] = 32'h1234_5066;
    walk(LA, 0, 0, 1, 32'h0, "R4");

    // R1, R2, R3: nonzero base, last indices, last offset
    lat = 1;
    mem[32'h3FFC >> 2] = 32'h0000_2067;
    mem[32'h2FFC >> 2] = 32'hFEDC_B067;
    walk(32'hFFFF_FFFF, 0, 0, 0, 32'h0000_3000, "R1");
    walk(32'hFFFF_F000, 1, 0, 1, 32'h0000_3000, "R2");

    // R13: a second request during a walk is ignored
    lat = 3;
    mem[PDE_A[13:2]] = 32'h0000_1027;
    mem[PTE_A[13:2]] = 32'h1234_5067;
    exp_q.push_back(predict(LA, 0, 0, 0, 32'h0));
    tag_q.push_back("R13");
    log_q.delete();
    @(negedge clk);
    req_valid = 1; req_laddr = LA; req_write = 0; req_user = 0; wp_en = 0; dir_base = 0;
    @(negedge clk);
    req_valid = 0;
    repeat (2) @(negedge clk);
    req_valid = 1; req_laddr = 32'h0000_0000; req_write = 1; req_user = 1;
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k < 400 && exp_q.size() != 0; k++) @(negedge clk);
    check(exp_q.size() == 0, "R13", "first walk result", 64'(exp_q.size()), 0);
    repeat (30) @(negedge clk);
    check(log_q.size() == 2, "R13", "ops after ignored request", 64'(log_q.size()), 2);
    check(!mem_req, "R13", "idle after ignored request", 64'(mem_req), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule